// File: doc/BRIEF.md
# Direct-Mapped Instruction Fetch Cache with Word Parity

This block sits between a processor front end and the memory system and supplies one 64-bit double word, that is two 32-bit instructions, per fetch. Each index holds one line: a tag, a valid bit, the double word, one parity bit for each 32-bit word and a one-bit predecode flag. The predecode flag says whether the two instructions of the pair may issue together. It is worked out when the line is filled and stored with the data.

A fetch is accepted with a valid/ready handshake. On a hit the stored double word comes back with its flag. On a miss, and also on a hit whose stored parity does not match, the block raises a line request toward memory and holds the fetch. When the double word arrives, the block writes tag, data, parity and flag in one clock, and passes the same data on as the response. A bad-parity line is never corrected. Its valid bit is cleared and the line is fetched again. A flush input walks every index and clears one valid bit per cycle.

Top module: `icp_fetch_cache`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid`, `fill_req_valid` and `flush_busy` are 0, and every entry is invalid, so the first fetch to any address misses.
- R2: A fetch accepted on a clock edge that hits returns `rsp_valid`=1, `rsp_hit`=1, the stored double word and its stored flag in the cycle after the next edge. `rsp_valid` lasts one cycle.
- R3: A fetch that misses raises `fill_req_valid` at the same point a hit would respond. `fill_req_addr` equals the fetch address with its three low bits cleared. Both hold steady until `fill_valid` is sampled high.
- R4: When `fill_valid` is sampled high during a line request, the whole double word, its parity, its flag and its tag are written in that clock. In the following cycle `rsp_valid`=1, `rsp_hit`=0 and `rsp_data` equals `fill_data`, and `fill_req_valid` is 0. A later fetch to the same line hits.
- R5: Word i of a line is bits [32i+31:32i]. Its parity bit is the XOR of its 32 bits. A valid, tag-matching entry with a parity mismatch in either word is treated as a miss: its valid bit is cleared and a line request follows.
- R6: The predecode flag is 1 exactly when bit 31 and bit 63 of the double word are both 0. `rsp_bundle` always matches this rule for the returned data.
- R7: The index is address bits [12:3] and the tag is bits [31:13] (default 1024 entries). A fill to an index replaces the line held there with any other tag. Address bits [2:0] do not affect hit or miss.
- R8: `flush_start` sampled high while idle makes `flush_busy` high for exactly ENTRIES cycles with `req_ready` low, after which every entry is invalid.
- R9: `req_ready` is 0 from the edge that accepts a fetch until its response is presented.
- R10: Bit i of `fill_par_flip`, sampled with `fill_valid`, inverts the parity bit stored for word i, so the next fetch of that line sees a parity error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Block can accept a fetch |
| req_addr | input | 32 | Byte address of the fetch |
| rsp_valid | output | 1 | Response present (one cycle) |
| rsp_data | output | 64 | Returned double word |
| rsp_hit | output | 1 | 1 if served from the array, 0 if from a fill |
| rsp_bundle | output | 1 | Predecode flag: the pair may issue together |
| fill_req_valid | output | 1 | Line request toward memory |
| fill_req_addr | output | 32 | Line-aligned address of the request |
| fill_valid | input | 1 | Fill data present |
| fill_data | input | 64 | Double word from memory |
| fill_par_flip | input | 2 | Per-word parity inversion applied on the fill write |
| flush_start | input | 1 | Start invalidating all entries |
| flush_busy | output | 1 | Invalidate walk in progress |

## Verification
A fetch accepted on edge E has its result due in the cycle after edge E+1: either the hit response or the raised line request. The fill response is due in the cycle after the edge that samples `fill_valid`, and a flush keeps `flush_busy` high for ENTRIES cycles. The bench drives on falling edges and samples on the falling edge of exactly those cycles. It also checks that nothing shows one cycle early, and that the line request holds during randomly stretched memory delays. Expected data, hit status and predecode flags come from a bench-side model of tags, data and injected parity faults.

// File: rtl/icp_pkg.sv
package icp_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned WORDS  = 2;
  localparam int unsigned LINE_W = WORD_W * WORDS;

  typedef enum logic [1:0] {ST_IDLE, ST_LOOK, ST_FILL, ST_FLUSH} fsm_e;

  // even parity over one instruction word
  function automatic logic word_par(input logic [WORD_W-1:0] w);
    return ^w;
  endfunction

  // stand-in pairing rule: no word may have its top opcode bit set
  function automatic logic pair_ok(input logic [LINE_W-1:0] d);
    logic any_top;
    any_top = 1'b0;
    for (int k = 0; k < int'(WORDS); k++) any_top |= d[k*WORD_W + WORD_W - 1];
    return !any_top;
  endfunction
endpackage

// File: rtl/icp_par_gen.sv
module icp_par_gen
  import icp_pkg::*;
(
  input  logic [LINE_W-1:0] line,
  input  logic [WORDS-1:0]  flip,
  output logic [WORDS-1:0]  par,
  output logic              bnd
);
  for (genvar g = 0; g < int'(WORDS); g++) begin : g_word
    assign par[g] = word_par(line[g*WORD_W +: WORD_W]) ^ flip[g];
  end
  assign bnd = pair_ok(line);
endmodule

// File: rtl/icp_par_chk.sv
module icp_par_chk
  import icp_pkg::*;
(
  input  logic [LINE_W-1:0] line,
  input  logic [WORDS-1:0]  par,
  output logic [WORDS-1:0]  err_vec,
  output logic              err
);
  for (genvar g = 0; g < int'(WORDS); g++) begin : g_word
    assign err_vec[g] = word_par(line[g*WORD_W +: WORD_W]) != par[g];
  end
  assign err = |err_vec;
endmodule

// File: rtl/icp_store.sv
module icp_store
  import icp_pkg::*;
#(
  parameter int unsigned ENTRIES = 1024,
  parameter int unsigned TAG_W   = 19,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data,
  input  logic [WORDS-1:0]  wr_par,
  input  logic              wr_bnd,
  input  logic              inv_en,
  input  logic [IDX_W-1:0]  inv_idx,
  output logic              rd_vld,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  output logic [WORDS-1:0]  rd_par,
  output logic              rd_bnd
);
  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_mem  [ENTRIES];
  logic [LINE_W-1:0]  data_mem [ENTRIES];
  logic [WORDS-1:0]   par_mem  [ENTRIES];
  logic               bnd_mem  [ENTRIES];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rd_vld <= 1'b0;
    end else begin
      if (wr_en)       vld[wr_idx]  <= 1'b1;
      else if (inv_en) vld[inv_idx] <= 1'b0;
      if (rd_en)       rd_vld <= vld[rd_idx];
    end
  end

  // payload: one-cycle write of the whole line
  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_idx]  <= wr_tag;
      data_mem[wr_idx] <= wr_data;
      par_mem[wr_idx]  <= wr_par;
      bnd_mem[wr_idx]  <= wr_bnd;
    end
    if (rd_en) begin
      rd_tag  <= tag_mem[rd_idx];
      rd_data <= data_mem[rd_idx];
      rd_par  <= par_mem[rd_idx];
      rd_bnd  <= bnd_mem[rd_idx];
    end
  end
endmodule

// File: rtl/icp_fetch_cache.sv
module icp_fetch_cache
  import icp_pkg::*;
#(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [LINE_W-1:0] rsp_data,
  output logic              rsp_hit,
  output logic              rsp_bundle,
  output logic              fill_req_valid,
  output logic [ADDR_W-1:0] fill_req_addr,
  input  logic              fill_valid,
  input  logic [LINE_W-1:0] fill_data,
  input  logic [WORDS-1:0]  fill_par_flip,
  input  logic              flush_start,
  output logic              flush_busy
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned OFF_W = $clog2(LINE_W / 8);
  localparam int unsigned TAG_W = ADDR_W - IDX_W - OFF_W;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  fsm_e             state;
  logic [TAG_W-1:0] cur_tag;
  logic [IDX_W-1:0] cur_idx;
  logic [IDX_W-1:0] flush_cnt;

  logic              rd_vld, rd_bnd;
  logic [TAG_W-1:0]  rd_tag;
  logic [LINE_W-1:0] rd_data;
  logic [WORDS-1:0]  rd_par;
  logic [WORDS-1:0]  gen_par, err_vec;
  logic              gen_bnd, par_err;

  // named internal events
  logic accept, tag_match, lookup_hit, lookup_perr, fill_write, inv_en;
  logic [IDX_W-1:0] inv_idx;
  logic unused_off;

  assign unused_off  = ^req_addr[OFF_W-1:0];
  assign req_ready   = (state == ST_IDLE) && !flush_start;
  assign accept      = req_valid && req_ready;
  assign tag_match   = (state == ST_LOOK) && rd_vld && (rd_tag == cur_tag);
  assign lookup_hit  = tag_match && !par_err;
  assign lookup_perr = tag_match && par_err;
  assign fill_write  = (state == ST_FILL) && fill_valid;
  assign inv_en      = lookup_perr || (state == ST_FLUSH);
  assign inv_idx     = (state == ST_FLUSH) ? flush_cnt : cur_idx;

  assign fill_req_valid = (state == ST_FILL);
  assign fill_req_addr  = {cur_tag, cur_idx, {OFF_W{1'b0}}};
  assign flush_busy     = (state == ST_FLUSH);

  icp_par_gen u_gen (
    .line (fill_data),
    .flip (fill_par_flip),
    .par  (gen_par),
    .bnd  (gen_bnd)
  );

  icp_par_chk u_chk_par (
    .line    (rd_data),
    .par     (rd_par),
    .err_vec (err_vec),
    .err     (par_err)
  );

  icp_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (accept),
    .rd_idx  (req_addr[OFF_W +: IDX_W]),
    .wr_en   (fill_write),
    .wr_idx  (cur_idx),
    .wr_tag  (cur_tag),
    .wr_data (fill_data),
    .wr_par  (gen_par),
    .wr_bnd  (gen_bnd),
    .inv_en  (inv_en),
    .inv_idx (inv_idx),
    .rd_vld  (rd_vld),
    .rd_tag  (rd_tag),
    .rd_data (rd_data),
    .rd_par  (rd_par),
    .rd_bnd  (rd_bnd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_tag   <= '0;
      cur_idx   <= '0;
      flush_cnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (flush_start) begin
            state     <= ST_FLUSH;
            flush_cnt <= '0;
          end else if (req_valid) begin
            state   <= ST_LOOK;
            cur_tag <= req_addr[ADDR_W-1 -: TAG_W];
            cur_idx <= req_addr[OFF_W +: IDX_W];
          end
        end
        ST_LOOK:  state <= lookup_hit ? ST_IDLE : ST_FILL;
        ST_FILL:  if (fill_valid) state <= ST_IDLE;
        ST_FLUSH: begin
          flush_cnt <= flush_cnt + 1'b1;
          if (flush_cnt == LAST_IDX) state <= ST_IDLE;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_hit    <= 1'b0;
      rsp_bundle <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      if (lookup_hit) begin
        rsp_valid  <= 1'b1;
        rsp_data   <= rd_data;
        rsp_hit    <= 1'b1;
        rsp_bundle <= rd_bnd;
      end else if (fill_write) begin
        rsp_valid  <= 1'b1;
        rsp_data   <= fill_data;
        rsp_hit    <= 1'b0;
        rsp_bundle <= gen_bnd;
      end
    end
  end
endmodule

// File: rtl/icp_fetch_cache_chk.sv
module icp_fetch_cache_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [63:0]       rsp_data,
  input logic              rsp_hit,
  input logic              rsp_bundle,
  input logic              fill_req_valid,
  input logic [ADDR_W-1:0] fill_req_addr,
  input logic              fill_valid,
  input logic              flush_busy,
  input logic              lookup_perr
);
  a_r2_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid && !fill_valid |=> fill_req_valid && $stable(fill_req_addr));

  a_r3_req_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> fill_req_addr[2:0] == 3'b000);

  a_r4_fill_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid && fill_valid |=> rsp_valid && !rsp_hit && !fill_req_valid);

  a_r5_perr_refill: assert property (@(posedge clk) disable iff (!rst_n)
    lookup_perr |=> fill_req_valid);

  a_r6_bundle_rule: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_bundle == (!rsp_data[31] && !rsp_data[63]));

  a_r8_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush_busy |-> !req_ready && !fill_req_valid);

  a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fill_req_valid |-> !req_ready);
endmodule

bind icp_fetch_cache icp_fetch_cache_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_icp_fetch_cache.sv
module sim_icp_fetch_cache;
  localparam int ENT = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_data;
  logic        rsp_hit;
  logic        rsp_bundle;
  logic        fill_req_valid;
  logic [31:0] fill_req_addr;
  logic        fill_valid = 1'b0;
  logic [63:0] fill_data = '0;
  logic [1:0]  fill_par_flip = '0;
  logic        flush_start = 1'b0;
  logic        flush_busy;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the array
  bit          m_vld  [ENT];
  logic [18:0] m_tag  [ENT];
  logic [63:0] m_data [ENT];
  logic [1:0]  m_flip [ENT];

  always #10 clk = ~clk;

  icp_fetch_cache u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_hit(rsp_hit),
    .rsp_bundle(rsp_bundle),
    .fill_req_valid(fill_req_valid), .fill_req_addr(fill_req_addr),
    .fill_valid(fill_valid), .fill_data(fill_data),
    .fill_par_flip(fill_par_flip),
    .flush_start(flush_start), .flush_busy(flush_busy)
  );

  function automatic logic exp_bundle(input logic [63:0] d);
    return ((d >> 31) & 64'd1) == 0 && ((d >> 63) & 64'd1) == 0;
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic do_fetch(input logic [31:0] a, input logic [1:0] flip,
                          input logic [63:0] d, input string rq);
    int idx;
    bit hit;
    idx = int'((a / 8) % ENT);
    hit = m_vld[idx] && m_tag[idx] == (a >> 13) && m_flip[idx] == 2'b00;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!rsp_valid && !fill_req_valid, "R2", {62'd0, rsp_valid, fill_req_valid}, 64'd0);
    chk(!req_ready, "R9", {63'd0, req_ready}, 64'd0);
    @(negedge clk);
    if (hit) begin
      chk(rsp_valid && rsp_hit, {rq, "/R2"}, {62'd0, rsp_valid, rsp_hit}, 64'd3);
      chk(rsp_data == m_data[idx], "R2", rsp_data, m_data[idx]);
      chk(rsp_bundle == exp_bundle(m_data[idx]), "R6", {63'd0, rsp_bundle},
          {63'd0, exp_bundle(m_data[idx])});
    end else begin
      chk(!rsp_valid && fill_req_valid, {rq, "/R3"},
          {62'd0, rsp_valid, fill_req_valid}, 64'd1);
      chk(fill_req_addr == (a & ~32'd7), "R3", {32'd0, fill_req_addr},
          {32'd0, a & ~32'd7});
      for (int w = $urandom % 4; w > 0; w--) begin
        @(negedge clk);
        chk(fill_req_valid && !rsp_valid, "R3", {63'd0, fill_req_valid}, 64'd1);
      end
      fill_valid    = 1'b1;
      fill_data     = d;
      fill_par_flip = flip;
      @(negedge clk);
      fill_valid    = 1'b0;
      fill_par_flip = 2'b00;
      chk(rsp_valid && !rsp_hit && !fill_req_valid, "R4",
          {61'd0, rsp_valid, rsp_hit, fill_req_valid}, 64'd4);
      chk(rsp_data == d, "R4", rsp_data, d);
      chk(rsp_bundle == exp_bundle(d), "R6", {63'd0, rsp_bundle},
          {63'd0, exp_bundle(d)});
      m_vld[idx]  = 1;
      m_tag[idx]  = a[31:13];
      m_data[idx] = d;
      m_flip[idx] = flip;
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < ENT; i++) begin
      m_vld[i] = 0; m_tag[i] = '0; m_data[i] = '0; m_flip[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(req_ready && !rsp_valid && !fill_req_valid && !flush_busy, "R1",
        {60'd0, req_ready, rsp_valid, fill_req_valid, flush_busy}, 64'h8);
    do_fetch(32'h0000_0100, 2'b00, 64'h1111_2222_3333_4444, "R1");
    do_fetch(32'h0000_0100, 2'b00, 64'h0, "R2");
    do_fetch(32'h0000_0104, 2'b00, 64'h0, "R7");
    // R7: same index, other tag evicts
    do_fetch(32'h0000_2100, 2'b00, 64'h8000_0000_0000_0001, "R7");
    do_fetch(32'h0000_0100, 2'b00, 64'h0123_4567_89AB_CDEF, "R7");
    do_fetch(32'h0000_2100, 2'b00, 64'h0000_0001_8000_0000, "R7");
    // R6: flag patterns
    do_fetch(32'h0000_0208, 2'b00, 64'h0000_0000_8000_0000, "R6");
    do_fetch(32'h0000_0208, 2'b00, 64'h0, "R6");
    do_fetch(32'h0000_0210, 2'b00, 64'h7FFF_FFFF_7FFF_FFFF, "R6");
    do_fetch(32'h0000_0210, 2'b00, 64'h0, "R6");
    // R5 / R10: parity fault in word 0, then word 1
    do_fetch(32'h0000_0300, 2'b01, 64'hDEAD_BEEF_0BAD_F00D, "R10");
    do_fetch(32'h0000_0300, 2'b00, 64'h0000_1111_0000_2222, "R5");
    do_fetch(32'h0000_0300, 2'b00, 64'h0, "R5");
    do_fetch(32'h0000_0308, 2'b10, 64'h1357_9BDF_2468_ACE0, "R10");
    do_fetch(32'h0000_0308, 2'b00, 64'h0F0F_0F0F_F0F0_F0F0, "R5");
    do_fetch(32'h0000_0308, 2'b00, 64'h0, "R5");
    // R8: flush
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    flush_start = 1'b1;
    @(negedge clk);
    flush_start = 1'b0;
    begin
      int n;
      n = 0;
      while (flush_busy && n < 5000) begin
        n++;
        if (req_ready) chk(0, "R8", {63'd0, req_ready}, 64'd0);
        @(negedge clk);
      end
      chk(n == ENT, "R8", 64'(n), 64'(ENT));
    end
    for (int i = 0; i < ENT; i++) m_vld[i] = 0;
    do_fetch(32'h0000_0100, 2'b00, 64'h0A0A_0A0A_0B0B_0B0B, "R8");
    do_fetch(32'h0000_0300, 2'b00, 64'h0C0C_0C0C_0D0D_0D0D, "R8");
    // random traffic
    for (int t = 0; t < 400; t++) begin
      logic [31:0] a;
      logic [63:0] d;
      logic [1:0]  f;
      a = (($urandom % 4) << 13) | (($urandom % 16) << 3) | ($urandom % 8);
      d = {$urandom, $urandom};
      if ($urandom % 2) d[31] = 1'b0;
      if ($urandom % 2) d[63] = 1'b0;
      f = ($urandom % 8 == 0) ? 2'(1 + $urandom % 3) : 2'b00;
      do_fetch(a, f, d, "R7");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule